// File: doc/BRIEF.md
# Exactly-Two Ones Stream Recognizer

This block watches a serial stream of one-bit symbols, one per clock, and reports whether the symbols consumed since the last reset contain exactly two ones. A zero symbol leaves the count alone. The block keeps a two-bit count state with four values: none seen, one seen, two seen, and too many. Once a third one arrives, the state stays at "too many" until reset.

A symbol is consumed only on a rising clock edge where the valid input is high. The accept output is a Moore output. It is decoded from the registered state, so it changes only after the edge that consumes a symbol.

The next state is computed by a small function for each state. A multiplexer, steered by the current state, then chooses which of these results is loaded into the state register.

Top module: `pair_b_recognizer`

## Requirements
- R1: While rst_ni is low, and right after it is released, accept_o is 0 and the count state is "none seen" (0).
- R2: A consumed symbol of value 0 leaves the state unchanged, so accept_o keeps its value.
- R3: A consumed symbol of value 1 moves the state from 0 to 1, and from 1 to 2. accept_o is 1 exactly while the state is 2, meaning exactly two ones have been consumed.
- R4: A consumed 1 in state 2 moves the state to 3 ("more than two"). State 3 stays 3 for every later symbol, so accept_o stays 0 until reset.
- R5: On an edge where sym_valid_i is 0, the state holds whatever the value of sym_i.
- R6: accept_o changes only after a rising clock edge. A symbol driven before an edge does not show on accept_o until that edge has passed.
- R7: The reset is asynchronous and active-low. Asserting it in the middle of a cycle clears accept_o at once, and counting restarts from 0 after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sym_valid_i | input | 1 | High when sym_i carries a symbol to consume |
| sym_i | input | 1 | Symbol value (0 or 1) |
| accept_o | output | 1 | High when exactly two ones have been consumed |

## Verification
The block has no tunable parameters. The bench therefore builds it with the package defaults: a two-bit state, four states, and the state-indexed multiplexer over all four per-state functions. With these defaults, every state, every transition and the trap state can be reached within a few symbols. The stimuli cover zeros interleaved between ones, idle cycles that present a 1 without valid, a run past the third one, and a reset asserted in the middle of a cycle.

// File: rtl/pair_b_pkg.sv
package pair_b_pkg;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_NONE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_OVER = 2'd3
  } cnt_state_e;

  localparam cnt_state_e ACCEPT_STATE = ST_TWO;
  localparam cnt_state_e TRAP_STATE   = ST_OVER;
endpackage

// File: rtl/pair_b_next_fn.sv
// Next-state function for one fixed current state.
module pair_b_next_fn
  import pair_b_pkg::*;
#(
  parameter int unsigned THIS_STATE = 0
) (
  input  logic               valid_i,
  input  logic               sym_i,
  output logic [STATE_W-1:0] next_o
);
  localparam logic [STATE_W-1:0] SELF = THIS_STATE[STATE_W-1:0];

  generate
    if (SELF == TRAP_STATE) begin : g_trap
      assign next_o = SELF;
    end else begin : g_step
      assign next_o = (valid_i && sym_i) ? SELF + 1'b1 : SELF;
    end
  endgenerate
endmodule

// File: rtl/pair_b_state_mux.sv
module pair_b_state_mux
  import pair_b_pkg::*;
(
  input  logic [NUM_STATES-1:0][STATE_W-1:0] cand_i,
  input  logic [STATE_W-1:0]                 sel_i,
  output logic [STATE_W-1:0]                 y_o
);
  assign y_o = cand_i[sel_i];
endmodule

// File: rtl/pair_b_recognizer.sv
module pair_b_recognizer
  import pair_b_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sym_valid_i,
  input  logic sym_i,
  output logic accept_o
);
  logic [NUM_STATES-1:0][STATE_W-1:0] cand;
  logic [STATE_W-1:0]                 state_q;
  logic [STATE_W-1:0]                 state_d;

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_fn
    pair_b_next_fn #(.THIS_STATE(s)) u_fn (
      .valid_i (sym_valid_i),
      .sym_i   (sym_i),
      .next_o  (cand[s])
    );
  end

  pair_b_state_mux u_mux (
    .cand_i (cand),
    .sel_i  (state_q),
    .y_o    (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NONE;
    else         state_q <= state_d;
  end

  assign accept_o = (state_q == ACCEPT_STATE);
endmodule

// File: rtl/pair_b_checker.sv
module pair_b_checker
  import pair_b_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sym_valid_i,
  input logic               sym_i,
  input logic               accept_o,
  input logic [STATE_W-1:0] state_q
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (state_q == ST_NONE && !accept_o));

  a_r2_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && !sym_i) |=> $stable(state_q));

  a_r3_one_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_i && state_q != TRAP_STATE) |=> state_q == $past(state_q) + 2'd1);

  a_r4_trap_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TRAP_STATE) |=> (state_q == TRAP_STATE && !accept_o));

  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> $stable(state_q));

  a_r6_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> $past(sym_valid_i && sym_i));
endmodule

bind pair_b_recognizer pair_b_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .sym_i       (sym_i),
  .accept_o    (accept_o),
  .state_q     (state_q)
);

// File: tb/pair_b_recognizer_tb.sv
`timescale 1ns/1ps
module pair_b_recognizer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic sym = 1'b0;
  logic acc;
  int   n_chk = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  pair_b_recognizer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sym_valid_i (vld),
    .sym_i       (sym),
    .accept_o    (acc)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (acc !== exp) begin
      n_fail++;
      $display("FAIL %s: accept_o=%b expected %b", tag, acc, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample at next negedge
  task automatic feed(input logic v, input logic s);
    vld = v;
    sym = s;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after release");
  endtask

  task automatic t_zeros();
    do_reset();
    for (int i = 0; i < 5; i++) begin
      feed(1'b1, 1'b0);
      check(1'b0, "R2 zeros only");
    end
  endtask

  task automatic t_two();
    do_reset();
    feed(1'b1, 1'b1); check(1'b0, "R3 first one");
    feed(1'b1, 1'b0); check(1'b0, "R2 zero after one");
    feed(1'b1, 1'b0); check(1'b0, "R2 zero after one");
    feed(1'b1, 1'b1); check(1'b1, "R3 second one");
    feed(1'b1, 1'b0); check(1'b1, "R2 zero keeps accept");
    feed(1'b1, 1'b0); check(1'b1, "R2 zero keeps accept");
  endtask

  task automatic t_idle();
    do_reset();
    feed(1'b0, 1'b1); check(1'b0, "R5 idle in state 0");
    feed(1'b1, 1'b1);
    feed(1'b0, 1'b1); check(1'b0, "R5 idle in state 1");
    feed(1'b1, 1'b1); check(1'b1, "R3 two ones around idle");
    for (int i = 0; i < 4; i++) begin
      feed(1'b0, 1'b1);
      check(1'b1, "R5 idle in state 2");
    end
  endtask

  task automatic t_trap();
    do_reset();
    feed(1'b1, 1'b1);
    feed(1'b1, 1'b1); check(1'b1, "R3 reach two");
    feed(1'b1, 1'b1); check(1'b0, "R4 third one");
    for (int i = 0; i < 3; i++) begin
      feed(1'b1, 1'b1); check(1'b0, "R4 trap on one");
      feed(1'b1, 1'b0); check(1'b0, "R4 trap on zero");
    end
  endtask

  task automatic t_latency();
    do_reset();
    feed(1'b1, 1'b1);
    vld = 1'b1;
    sym = 1'b1;
    #5;
    check(1'b0, "R6 before edge");
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    check(1'b1, "R6 after edge");
  endtask

  task automatic t_async();
    do_reset();
    feed(1'b1, 1'b1);
    feed(1'b1, 1'b1); check(1'b1, "R7 precondition");
    #3;
    rst_n = 1'b0;
    #1;
    check(1'b0, "R7 mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    feed(1'b1, 1'b1); check(1'b0, "R7 recount one");
    feed(1'b1, 1'b1); check(1'b1, "R7 recount two");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_zeros();
    t_two();
    t_idle();
    t_trap();
    t_latency();
    t_async();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule